// File: doc/BRIEF.md
# Stop-mode wake and clock-enable controller

This block sits beside the core of a small microcontroller and owns one 8-bit power-management control register. Software writes the register over a simple register bus. The register chooses which external pin, or which group of pins, may end STOP mode. It also sets the logic level that counts as active for that source and the length of the reset delay that follows a wake. A further two bits shape the clock-enable strobes that pace the system and timer logic. A sticky flag records that the device has come out of STOP through the pin-wake path. Only a power-on reset clears that flag.

The selected source is picked and level-adjusted combinationally. It then passes through a two-flop synchronizer on the input clock. A three-state machine tracks the stop request:
- ST_RUN goes to ST_STOP when `stop_in` rises.
- ST_STOP goes to ST_RECOVER on a synchronized hit, and drives a one-cycle `wake_o` in that cycle. It returns to ST_RUN if `stop_in` drops without a hit, which happens when a reset ended STOP.
- ST_RECOVER goes to ST_RUN when `stop_in` falls.

The strobes run at the input rate divided by 1, 2, 16 or 32. They are held low while `stop_in` is high, and their counters restart from zero on release and on wake.

Top module: `stopwake_ctrl`

## Requirements
- R1: After power-on reset, and after an external reset, the control bits 6:0 are all 0. A read at the register address returns 0x00 after power-on reset, `wake_o` and `dly_sel_o` are 0, and the strobes pulse every 2 input clocks.
- R2: Source code (bits 4:2) 1, 2, 3 or 4 selects `wk_pa_in[0]`, `[1]`, `[2]` or `[3]`. Code 5 selects `wk_pb_in[7]`, code 6 the NOR of `wk_pb_in[3:0]`, and code 7 the NOR of all of `wk_pb_in`. With `stop_in` high and the machine in ST_STOP, a selected source that becomes active at a drive point is seen as `wake_o` high two input clocks later. Activity on unselected pins causes no wake.
- R3: Bit 6 sets the active level: 0 means a low source wakes, 1 means a high source wakes.
- R4: With source code 0, no pin activity at either level produces `wake_o`.
- R5: Bit 7 (the flag) is set by a wake. It is unchanged by register writes and by an external reset, and it is cleared only by power-on reset. A read at the register address returns {flag, 7'b0}.
- R6: Bit 1 = 1 removes the divide-by-two, and bit 0 = 1 adds a divide-by-16. The strobe period is 1 for {bit1,bit0} = 10, 2 for 00, 16 for 11 and 32 for 01 input clocks.
- R7: A wake clears bit 0, so after recovery the strobe period falls back to the bit-1 rate alone.
- R8: While `stop_in` is high, both strobes are 0. After `stop_in` falls, the first strobe is seen max(1, period-1) sampled cycles later, which shows the counters restart from zero.
- R9: Writes to any address other than 0x0B leave the register unchanged. Reads at other addresses return 0.
- R10: `dly_sel_o` follows bit 5 (1 selects the short recovery delay).
- R11: Each stop episode produces at most one `wake_o` pulse, one cycle long. Further source activity before `stop_in` falls is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| ext_rst_n | input | 1 | External reset, synchronous, active low; keeps the flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, {flag, 7'b0} at the register address |
| stop_in | input | 1 | STOP request from the core |
| wk_pa_in | input | 4 | Wake-capable pins, group A |
| wk_pb_in | input | 8 | Wake-capable pins, group B |
| wake_o | output | 1 | One-cycle wake pulse to the core |
| dly_sel_o | output | 1 | Reset-delay select: 1 short recovery delay, 0 power-on delay |
| sys_ce_o | output | 1 | System-domain clock-enable strobe |
| tmr_ce_o | output | 1 | Timer-domain clock-enable strobe |

## Verification
The bench builds the block with its default parameters: register address 0x0B, two synchronizer stages and a 4-bit second prescaler stage. These values keep the period-16 and period-32 strobe cases short enough to measure both the gap between strobes and the restart phase after release. The two-stage synchronizer makes the wake latency exactly two clocks. A scoreboard can therefore predict the cycle of every wake pulse and flag any pulse that was not predicted. That covers wrong source selection, wrong level handling, code 0 and repeated wakes within one stop episode.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_STOP,
        ST_RECOVER
    } swk_state_e;

    // Field order matches the software-visible bit positions (7 down to 0).
    typedef struct packed {
        logic       flag;
        logic       level;
        logic       short_dly;
        logic [2:0] src;
        logic       fast;
        logic       slow16;
    } swk_ctl_t;

    localparam logic [2:0] SRC_NONE    = 3'd0;
    localparam logic [2:0] SRC_PB7     = 3'd5;
    localparam logic [2:0] SRC_NOR_LO  = 3'd6;
    localparam logic [2:0] SRC_NOR_ALL = 3'd7;

endpackage

// File: rtl/swk_reg.sv
module swk_reg
    import stopwake_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0B
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              recover,
    output swk_ctl_t          ctl_o
);

    swk_ctl_t ctl_q;
    logic     hit_wr;

    assign hit_wr = wr_en && (addr == REG_ADDR);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '0;
        end else if (!ext_rst_n) begin
            ctl_q.level     <= 1'b0;
            ctl_q.short_dly <= 1'b0;
            ctl_q.src       <= SRC_NONE;
            ctl_q.fast      <= 1'b0;
            ctl_q.slow16    <= 1'b0;
        end else begin
            if (hit_wr) begin
                ctl_q.level     <= wdata[6];
                ctl_q.short_dly <= wdata[5];
                ctl_q.src       <= wdata[4:2];
                ctl_q.fast      <= wdata[1];
                ctl_q.slow16    <= wdata[0];
            end
            if (recover) begin
                ctl_q.slow16 <= 1'b0;
                ctl_q.flag   <= 1'b1;
            end
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/swk_wake.sv
module swk_wake
    import stopwake_pkg::*;
#(
    parameter int PA_W        = 4,
    parameter int PB_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            ext_rst_n,
    input  logic            stop_in,
    input  logic [2:0]      src,
    input  logic            level,
    input  logic [PA_W-1:0] pa_in,
    input  logic [PB_W-1:0] pb_in,
    output logic            wake_o
);

    localparam int PB_HALF = PB_W / 2;

    swk_state_e             state_q, state_d;
    logic                   raw_sel;
    logic                   active;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hit;

    always_comb begin
        case (src)
            3'd1:        raw_sel = pa_in[0];
            3'd2:        raw_sel = pa_in[1];
            3'd3:        raw_sel = pa_in[2];
            3'd4:        raw_sel = pa_in[3];
            SRC_PB7:     raw_sel = pb_in[PB_W-1];
            SRC_NOR_LO:  raw_sel = ~|pb_in[PB_HALF-1:0];
            SRC_NOR_ALL: raw_sel = ~|pb_in;
            default:     raw_sel = 1'b0;
        endcase
    end

    assign active = (raw_sel == level) && (src != SRC_NONE);

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= active;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign hit = sync_q[SYNC_STAGES-1] && (src != SRC_NONE);

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          state_q <= ST_RUN;
        else if (!ext_rst_n) state_q <= ST_RUN;
        else                 state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (stop_in) state_d = ST_STOP;
            ST_STOP: begin
                if (!stop_in) state_d = ST_RUN;
                else if (hit) state_d = ST_RECOVER;
            end
            ST_RECOVER: if (!stop_in) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        wake_o = 1'b0;
        unique case (state_q)
            ST_STOP:    wake_o = stop_in && hit && ext_rst_n;
            ST_RUN,
            ST_RECOVER: wake_o = 1'b0;
            default:    wake_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/swk_clkdiv.sv
module swk_clkdiv #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic hold,
    input  logic restart,
    input  logic fast,
    input  logic slow16,
    output logic sys_ce_o,
    output logic tmr_ce_o
);

    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic             half_q;
    logic [PRE_W-1:0] pre_q;
    logic             base_en;
    logic             slow_en;
    logic             ce;

    assign base_en = fast ? 1'b1 : half_q;
    assign slow_en = base_en && (pre_q == PRE_LAST);
    assign ce      = !hold && (slow16 ? slow_en : base_en);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            half_q <= 1'b0;
            pre_q  <= '0;
        end else if (!ext_rst_n || hold || restart) begin
            half_q <= 1'b0;
            pre_q  <= '0;
        end else begin
            half_q <= ~half_q;
            if (base_en) pre_q <= pre_q + 1'b1;
        end
    end

    assign sys_ce_o = ce;
    assign tmr_ce_o = ce;

endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
    import stopwake_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h0B,
    parameter int                SYNC_STAGES = 2,
    parameter int                PRE_W       = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              stop_in,
    input  logic [3:0]        wk_pa_in,
    input  logic [7:0]        wk_pb_in,
    output logic              wake_o,
    output logic              dly_sel_o,
    output logic              sys_ce_o,
    output logic              tmr_ce_o
);

    swk_ctl_t ctl_q;
    logic     wake;

    swk_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .ext_rst_n (ext_rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .recover   (wake),
        .ctl_o     (ctl_q)
    );

    swk_wake #(.PA_W(4), .PB_W(8), .SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk       (clk),
        .por_n     (por_n),
        .ext_rst_n (ext_rst_n),
        .stop_in   (stop_in),
        .src       (ctl_q.src),
        .level     (ctl_q.level),
        .pa_in     (wk_pa_in),
        .pb_in     (wk_pb_in),
        .wake_o    (wake)
    );

    swk_clkdiv #(.PRE_W(PRE_W)) u_div (
        .clk       (clk),
        .por_n     (por_n),
        .ext_rst_n (ext_rst_n),
        .hold      (stop_in),
        .restart   (wake),
        .fast      (ctl_q.fast),
        .slow16    (ctl_q.slow16),
        .sys_ce_o  (sys_ce_o),
        .tmr_ce_o  (tmr_ce_o)
    );

    assign reg_rdata = (reg_addr == REG_ADDR) ? {ctl_q.flag, 7'b0} : 8'h00;
    assign wake_o    = wake;
    assign dly_sel_o = ctl_q.short_dly;

endmodule

// File: rtl/stopwake_ctrl_chk.sv
module stopwake_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       stop_in,
    input logic       wake_o,
    input logic       sys_ce_o,
    input logic       tmr_ce_o,
    input logic       flag,
    input logic [2:0] src
);

    AST_WAKE_NEEDS_STOP: assert property (@(posedge clk) disable iff (!por_n)
        wake_o |-> stop_in); // R2

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        wake_o |=> !wake_o); // R11

    AST_CE_HELD: assert property (@(posedge clk) disable iff (!por_n)
        stop_in |-> (!sys_ce_o && !tmr_ce_o)); // R8

    AST_SRC0_NO_WAKE: assert property (@(posedge clk) disable iff (!por_n)
        (src == 3'd0) |-> !wake_o); // R4

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
        wake_o |=> flag); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        flag |=> flag); // R5

endmodule

bind stopwake_ctrl stopwake_ctrl_chk u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .stop_in  (stop_in),
    .wake_o   (wake_o),
    .sys_ce_o (sys_ce_o),
    .tmr_ce_o (tmr_ce_o),
    .flag     (ctl_q.flag),
    .src      (ctl_q.src)
);

// File: tb/stopwake_ctrl_tb_top.sv
module stopwake_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam logic [7:0] RA = 8'h0B;

    logic       clk = 1'b0;
    logic       por_n, ext_rst_n, reg_wr, stop_in;
    logic [7:0] reg_addr, reg_wdata, reg_rdata, wk_pb_in;
    logic [3:0] wk_pa_in;
    logic       wake_o, dly_sel_o, sys_ce_o, tmr_ce_o;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    int wakes = 0;
    int exp_q[$];
    int exp_c;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stopwake_ctrl dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stop_in(stop_in), .wk_pa_in(wk_pa_in), .wk_pb_in(wk_pb_in),
        .wake_o(wake_o), .dly_sel_o(dly_sel_o), .sys_ce_o(sys_ce_o),
        .tmr_ce_o(tmr_ce_o)
    );

    // Scoreboard monitor: every wake pulse must match the next predicted cycle.
    always @(negedge clk) begin
        if (wake_o) begin
            wakes++;
            nchk++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R2/R4/R11 unexpected wake at cycle %0d (expected none)", cyc);
            end else begin
                exp_c = exp_q.pop_front();
                if (exp_c != cyc) begin
                    nfail++;
                    $display("FAIL R2 wake cycle actual=%0d expected=%0d", cyc, exp_c);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0; reg_addr = RA;
    endtask

    task automatic expect_wake();
        exp_q.push_back(cyc + 2);
    endtask

    // Stop is already high: check strobes stay low, release, then time strobes.
    task automatic release_measure(string tag, int ratio);
        int bad = 0;
        int first = 0;
        int second = 0;
        int mism = 0;
        repeat (3) begin
            @(negedge clk);
            if (sys_ce_o || tmr_ce_o) bad++;
        end
        #1;
        chk("R8 strobes held low during stop", bad, 0);
        stop_in = 1'b0;
        for (int k = 1; k <= 70; k++) begin
            @(negedge clk);
            if (sys_ce_o !== tmr_ce_o) mism++;
            if (sys_ce_o) begin
                if (first == 0) first = k;
                else if (second == 0) second = k;
            end
        end
        #1;
        chk({tag, " first strobe phase (R8 restart)"}, first, (ratio > 1) ? ratio - 1 : 1);
        chk({tag, " strobe period"}, second - first, ratio);
        chk({tag, " domain strobes equal"}, mism, 0);
    endtask

    task automatic measure(string tag, int ratio);
        stop_in = 1'b1;
        release_measure(tag, ratio);
    endtask

    initial begin
        #(CLK_P * 150000);
        nfail++;
        $display("FAIL watchdog expired (expected completion)");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        por_n = 1'b0; ext_rst_n = 1'b1; reg_wr = 1'b0; reg_addr = RA;
        reg_wdata = 8'h00; stop_in = 1'b0; wk_pa_in = 4'h0; wk_pb_in = 8'hFF;
        tick(3);
        por_n = 1'b1;
        tick(2);

        // R1: reset state
        chk("R1 rdata after por", reg_rdata, 8'h00);
        chk("R1 wake after por", wake_o, 1'b0);
        chk("R1 dly_sel after por", dly_sel_o, 1'b0);
        measure("R1 default divide", 2);

        // R6: all four ratios
        wr(RA, 8'h02); measure("R6 ratio1", 1);
        wr(RA, 8'h01); measure("R6 ratio32", 32);
        wr(RA, 8'h03); measure("R6 ratio16", 16);
        wr(RA, 8'h00); measure("R6 ratio2", 2);

        // R10: delay select follows bit 5
        wr(RA, 8'h20); chk("R10 dly_sel set", dly_sel_o, 1'b1);
        wr(RA, 8'h00); chk("R10 dly_sel clear", dly_sel_o, 1'b0);

        // R4: code 0 never wakes, either level
        for (int lv = 0; lv < 2; lv++) begin
            wr(RA, lv ? 8'h40 : 8'h00);
            stop_in = 1'b1; tick(3);
            for (int t = 0; t < 6; t++) begin
                wk_pa_in = (t % 2) ? 4'hF : 4'h0;
                wk_pb_in = (t % 2) ? 8'h00 : 8'hFF;
                tick(3);
            end
            stop_in = 1'b0; wk_pa_in = 4'h0; wk_pb_in = 8'hFF; tick(3);
        end
        chk("R4 no wake with code 0", wakes, 0);

        // R3: low level on code 2, with unselected pins toggling first (R2)
        wr(RA, 8'h08);
        wk_pa_in = 4'hF; tick(3);
        stop_in = 1'b1; tick(3);
        wk_pa_in = 4'b0010; tick(4);
        chk("R2 unselected pins give no wake", wakes, 0);
        expect_wake(); wk_pa_in = 4'b0000; tick(4);
        chk("R3 low level wake", wakes, 1);
        stop_in = 1'b0; tick(3);
        chk("R5 flag set after wake", reg_rdata, 8'h80);

        // R2/R3: high level on codes 1..4
        for (int i = 0; i < 4; i++) begin
            wr(RA, 8'h40 | 8'((i + 1) << 2));
            wk_pa_in = 4'h0; tick(3);
            stop_in = 1'b1; tick(3);
            wk_pa_in = ~(4'b0001 << i); tick(4);
            expect_wake(); wk_pa_in = 4'hF; tick(4);
            stop_in = 1'b0; wk_pa_in = 4'h0; tick(3);
        end
        chk("R2 group A pins each wake once", wakes, 5);

        // R2: code 5, single group-B pin
        wr(RA, 8'h54); wk_pb_in = 8'h7F; tick(3);
        stop_in = 1'b1; tick(3);
        expect_wake(); wk_pb_in = 8'hFF; tick(4);
        stop_in = 1'b0; tick(3);
        chk("R2 code5 wake", wakes, 6);

        // R2: code 6, NOR of low nibble
        wr(RA, 8'h58); wk_pb_in = 8'hF1; tick(3);
        stop_in = 1'b1; tick(3);
        expect_wake(); wk_pb_in = 8'hF0; tick(4);
        stop_in = 1'b0; wk_pb_in = 8'hFF; tick(3);
        chk("R2 code6 wake", wakes, 7);

        // R2: code 7, NOR of all eight; upper-only activity must not wake
        wr(RA, 8'h5C); wk_pb_in = 8'h01; tick(3);
        stop_in = 1'b1; tick(3);
        wk_pb_in = 8'h80; tick(4);
        chk("R2 code7 partial no wake", wakes, 7);
        expect_wake(); wk_pb_in = 8'h00; tick(4);
        stop_in = 1'b0; wk_pb_in = 8'hFF; tick(3);
        chk("R2 code7 wake", wakes, 8);

        // R7/R11: recovery clears divide-by-16, single pulse per episode
        wr(RA, 8'h67);
        chk("R10 dly_sel with short delay", dly_sel_o, 1'b1);
        wk_pa_in = 4'h0; tick(3);
        stop_in = 1'b1; tick(3);
        expect_wake(); wk_pa_in = 4'b0001; tick(4);
        tick(10);
        wk_pa_in = 4'h0; tick(3);
        wk_pa_in = 4'b0001; tick(4);
        chk("R11 one wake per stop episode", wakes, 9);
        wk_pa_in = 4'h0; tick(1);
        release_measure("R7 divide-by-16 cleared", 1);

        // R9: other address ignored, reads there return 0
        wr(RA, 8'h00);
        wr(8'h0A, 8'h02);
        measure("R9 foreign write ignored", 2);
        reg_addr = 8'h0A; tick(1);
        chk("R9 foreign read zero", reg_rdata, 8'h00);
        reg_addr = RA; tick(1);

        // R5: sticky against writes and external reset
        wr(RA, 8'h7F); wr(RA, 8'h00);
        chk("R5 flag kept after writes", reg_rdata, 8'h80);
        wr(RA, 8'h63);
        ext_rst_n = 1'b0; tick(1); ext_rst_n = 1'b1; tick(1);
        chk("R5 flag kept after ext reset", reg_rdata, 8'h80);
        chk("R1 dly_sel cleared by ext reset", dly_sel_o, 1'b0);
        measure("R1 ext reset defaults", 2);
        por_n = 1'b0; tick(2); por_n = 1'b1; tick(2);
        chk("R5 flag cleared by por", reg_rdata, 8'h00);

        tick(5);
        chk("R2 all predicted wakes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule